// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block chooses which of several DMA channels is served next. Each channel has a hardware request line, which is asynchronous to the clock, and a software request bit. Hardware lines pass through a two-flop synchronizer. They are then polarity-corrected and gated by a per-channel mask. Software bits ignore the mask. The eligible set goes to a priority search. That search is either fixed, with channel 0 first, or rotating, where the channel served last drops to the bottom.

The transfer sequencer raises `grant_req` when it is ready to serve. At that moment the arbiter captures the current winner and holds it until `svc_done`. While the sequencer signals `ack_phase`, the arbiter drives a one-hot acknowledge for the held channel. The acknowledge uses a programmable level, and all other lines stay at the inactive level. Bus handshaking and data movement belong to the sequencer.

Top module: `dma_req_arbiter`

## Requirements
- R1: A change on `hw_req` is synchronized through two flops. A value driven between two rising edges affects `pending` and `win_chan` only after the second rising edge that follows it, never after the first.
- R2: With `req_active_low`=0, a synchronized 1 on a hardware line is a request. With `req_active_low`=1, a synchronized 0 is a request.
- R3: `req_mask[i]`=1 suppresses the hardware request of channel i. `sw_req[i]`=1 makes channel i eligible whatever its mask bit.
- R4: With `rotate_en`=0, the eligible channel with the lowest index wins.
- R5: With `rotate_en`=1, a `svc_done` pulse naming channel c makes the search start at channel (c+1) mod 4 and wrap, so that c is the lowest priority from the next cycle on.
- R6: While `rotate_en`=0 the rotation point is forced back to the default. From the first edge with `rotate_en` low, channel 0 is again highest.
- R7: After reset the arbiter holds no channel, the rotation point is the default (channel 0 highest), the synchronizer holds zeros, and every `ack` line is 1, because the default acknowledge level is active low.
- R8: A `grant_req` while nothing is held and `pending`=1 captures the current winner. From then on, `win_chan` shows that channel, unchanged, until the edge that samples `svc_done`, even if a higher-priority request arrives.
- R9: `ack` carries the held channel's line at its active level only while a channel is held and `ack_phase`=1. Otherwise every line sits at its inactive level.
- R10: With `ack_active_high`=0 the active acknowledge level is 0 and the inactive level is 1. With `ack_active_high`=1 the levels are swapped.
- R11: `pending` is 1 exactly when at least one channel is eligible. While nothing is held, `win_chan` shows the current winner combinationally.
- R12: A `grant_req` when `pending`=0 captures nothing. The acknowledge stays inactive, and `win_chan` keeps following the live search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | NCH | Asynchronous hardware request lines |
| req_mask | input | NCH | Per-channel hardware request mask, 1 = masked |
| sw_req | input | NCH | Software requests that bypass the mask |
| req_active_low | input | 1 | 1 = hardware requests are active low |
| rotate_en | input | 1 | 1 = rotating priority, 0 = fixed priority |
| ack_active_high | input | 1 | 1 = acknowledge lines are active high |
| grant_req | input | 1 | Sequencer asks to capture the winner |
| ack_phase | input | 1 | Sequencer is in its acknowledge phase |
| svc_done | input | 1 | Service of a channel completed |
| svc_chan | input | IDXW | Index of the channel whose service completed |
| pending | output | 1 | At least one channel is eligible |
| win_chan | output | IDXW | Held channel, or the live winner when none is held |
| ack | output | NCH | One-hot acknowledge with programmable level |

## Verification
Fixed priority is tried with sparse request sets, such as channels 1 and 3 together, to show that the lowest index wins. Rotating priority is tried with all four channels requesting, so each `svc_done` must move the winner to the next index and wrap from 3 to 0. Polarity and masking are each tried with the other setting held constant. This separates an inverted line from a masked one, and a software bit from a hardware bit. A long run of random inputs, compared every cycle against a behavioural model, brings out interactions: `grant_req` racing `svc_done`, mode switches in the middle of a service, and requests arriving while a channel is held.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  hw_req,
  input  logic [NCH-1:0]  req_mask,
  input  logic [NCH-1:0]  sw_req,
  input  logic            req_active_low,
  input  logic            rotate_en,
  input  logic            ack_active_high,
  input  logic            grant_req,
  input  logic            ack_phase,
  input  logic            svc_done,
  input  logic [IDXW-1:0] svc_chan,
  output logic            pending,
  output logic [IDXW-1:0] win_chan,
  output logic [NCH-1:0]  ack
);

  localparam logic [IDXW-1:0] LAST_DEF = IDXW'(NCH - 1);

  logic [NCH-1:0]   sync_q [SYNC_STAGES];
  logic [NCH-1:0]   hw_on, elig, ack_raw;
  logic [2*NCH-1:0] dbl;
  logic [IDXW-1:0]  cand, held, last;
  logic             busy;
  int               start_i, off_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= hw_req;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign hw_on   = sync_q[SYNC_STAGES-1] ^ {NCH{req_active_low}};
  assign elig    = (hw_on & ~req_mask) | sw_req;
  assign pending = |elig;

  always_comb begin
    start_i = (int'(last) + 1) % NCH;
    dbl     = {elig, elig} >> start_i;
    off_i   = 0;
    for (int i = NCH - 1; i >= 0; i--)
      if (dbl[i]) off_i = i;
    cand = IDXW'((start_i + off_i) % NCH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      held <= '0;
      last <= LAST_DEF;
    end else begin
      if (busy && svc_done)
        busy <= 1'b0;
      else if (!busy && grant_req && pending) begin
        busy <= 1'b1;
        held <= cand;
      end
      if (!rotate_en)
        last <= LAST_DEF;
      else if (svc_done)
        last <= svc_chan;
    end
  end

  assign win_chan = busy ? held : cand;
  assign ack_raw  = (busy && ack_phase) ? (NCH'(1) << held) : '0;
  assign ack      = ack_active_high ? ack_raw : ~ack_raw;

  p_ack_inactive_r9: assert property (@(posedge clk) disable iff (rst)
    !ack_phase |-> ((ack_active_high ? ack : ~ack) == '0));

  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_active_high ? ack : ~ack));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !svc_done) |=> $stable(win_chan));

  p_sw_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (|sw_req) |-> pending);

  p_fixed_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!rotate_en && $past(!rotate_en) && !busy && sw_req[0]) |-> (win_chan == '0));

  p_idle_grant_r12: assert property (@(posedge clk) disable iff (rst)
    (!busy && grant_req && !pending && !svc_done) |=> !busy);

endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  logic clk = 0, rst = 1;
  logic [3:0] hw_req = 0, req_mask = 0, sw_req = 0;
  logic req_active_low = 0, rotate_en = 0, ack_active_high = 0;
  logic grant_req = 0, ack_phase = 0, svc_done = 0;
  logic [1:0] svc_chan = 0;
  logic pending;
  logic [1:0] win_chan;
  logic [3:0] ack;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string phase = "R7";

  logic [3:0] m_s1 = 0, m_s2 = 0;
  int m_last = 3, m_held = 0;
  bit m_busy = 0;

  always #2 clk = ~clk;

  dma_req_arbiter i_dma_req_arbiter (
    .clk(clk), .rst(rst), .hw_req(hw_req), .req_mask(req_mask), .sw_req(sw_req),
    .req_active_low(req_active_low), .rotate_en(rotate_en),
    .ack_active_high(ack_active_high), .grant_req(grant_req), .ack_phase(ack_phase),
    .svc_done(svc_done), .svc_chan(svc_chan), .pending(pending),
    .win_chan(win_chan), .ack(ack));

  function automatic logic [3:0] m_elig();
    return ((m_s2 ^ {4{req_active_low}}) & ~req_mask) | sw_req;
  endfunction

  function automatic int m_cand();
    logic [3:0] e = m_elig();
    for (int k = 1; k <= 4; k++)
      if (e[(m_last + k) % 4]) return (m_last + k) % 4;
    return (m_last + 1) % 4;
  endfunction

  function automatic logic [3:0] m_ack();
    logic [3:0] r = 0;
    if (m_busy && ack_phase) r[m_held] = 1'b1;
    return ack_active_high ? r : ~r;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_last = 3; m_held = 0; m_busy = 0;
    end else begin
      bit pend = |m_elig();
      int c = m_cand();
      if (m_busy && svc_done) m_busy = 0;
      else if (!m_busy && grant_req && pend) begin m_busy = 1; m_held = c; end
      if (!rotate_en) m_last = 3;
      else if (svc_done) m_last = svc_chan;
      m_s2 = m_s1;
      m_s1 = hw_req;
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({phase, " model pending"}, pending, |m_elig());
    check({phase, " model win_chan"}, win_chan, m_busy ? m_held : m_cand());
    check({phase, " model ack"}, ack, m_ack());
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rst = 0;
    tick();
    check("R7 reset ack", ack, 4'hF);
    check("R7 reset pending", pending, 0);
    check("R7 reset win", win_chan, 0);

    phase = "R1";
    hw_req = 4'b0100;
    tick();
    check("R1 after one edge", pending, 0);
    tick();
    check("R1 after two edges", pending, 1);
    check("R1 winner", win_chan, 2);

    phase = "R2";
    req_active_low = 1;
    tick();
    check("R2 low-active winner", win_chan, 0);
    hw_req = 4'hF;
    ticks(2);
    check("R2 all high inactive", pending, 0);
    req_active_low = 0;
    tick();

    phase = "R3";
    req_mask = 4'hF;
    tick();
    check("R3 masked hw", pending, 0);
    sw_req = 4'b0100;
    tick();
    check("R3 sw bypass pending", pending, 1);
    check("R3 sw bypass win", win_chan, 2);
    sw_req = 0; req_mask = 0;

    phase = "R4";
    hw_req = 4'b1010;
    ticks(3);
    check("R4 fixed lowest index", win_chan, 1);

    phase = "R8";
    grant_req = 1;
    tick();
    grant_req = 0; ack_phase = 1;
    tick();
    check("R9 ack active low", ack, 4'b1101);
    phase = "R10";
    ack_active_high = 1;
    tick();
    check("R10 ack active high", ack, 4'b0010);
    ack_active_high = 0;
    phase = "R8";
    sw_req = 4'b0001;
    tick();
    check("R8 no preempt", win_chan, 1);
    svc_done = 1; svc_chan = 1;
    tick();
    svc_done = 0;
    phase = "R9";
    check("R9 released win", win_chan, 0);
    check("R9 ack inactive", ack, 4'hF);
    ack_phase = 0;
    tick();

    phase = "R5";
    rotate_en = 1; sw_req = 4'hF; hw_req = 0;
    tick();
    svc_done = 1; svc_chan = 2;
    tick();
    check("R5 after 2", win_chan, 3);
    svc_chan = 3;
    tick();
    check("R5 wrap after 3", win_chan, 0);
    svc_chan = 0;
    tick();
    check("R5 after 0", win_chan, 1);
    svc_done = 0;
    tick();

    phase = "R6";
    rotate_en = 0;
    tick();
    check("R6 fixed restored", win_chan, 0);

    phase = "R12";
    sw_req = 0; hw_req = 0;
    ticks(3);
    grant_req = 1; ack_phase = 1;
    tick();
    grant_req = 0;
    check("R12 no capture ack", ack, 4'hF);
    sw_req = 4'b1000;
    tick();
    check("R12 live winner", win_chan, 3);
    check("R11 pending", pending, 1);
    ack_phase = 0; sw_req = 0;
    tick();

    phase = "R11 random";
    for (int i = 0; i < 2000; i++) begin
      hw_req = 4'($urandom);
      req_mask = 4'($urandom);
      sw_req = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      req_active_low = ($urandom % 16 == 0) ? ~req_active_low : req_active_low;
      rotate_en = ($urandom % 32 == 0) ? ~rotate_en : rotate_en;
      ack_active_high = ($urandom % 32 == 0) ? ~ack_active_high : ack_active_high;
      grant_req = ($urandom % 3 == 0);
      ack_phase = ($urandom % 2 == 0);
      svc_done = ($urandom % 5 == 0);
      svc_chan = 2'($urandom);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule